// File: doc/BRIEF.md
# ARX Processing Element

This block is one processing element of a coarse-grained reconfigurable array built for add-rotate-xor style ciphers and hashes. It holds a small local register file of 64-bit words. Each accepted issue reads up to three operands from that file and passes them through three operator stages. Each stage can add modulo 2^64, rotate left, exclusive-or, or pass its input through. A configuration word chooses which operator each stage applies, so the element can apply one, two or three primitive operations in any order within a single cycle.

In parallel mode the first two stages work as independent units on separate operands. Each unit then writes its own result, using two write ports. The element rejects any configuration that uses one operator twice in the same cycle. A load form of the issue seeds the register file with data from outside. Results appear on registered output ports in the cycle after issue and are written back to the register file at the end of that cycle. The issue handshake stalls for that one cycle.

Top module: `arx_pe`

## Requirements
- R1: After reset, issueReady is 1, wrA, wrB and errOut are 0, resA and resB are 0, and every register-file entry reads as 0.
- R2: The 37-bit configuration word is laid out MSB to LSB as: parallel-mode bit [36], rotate-from-side bit [35], 6-bit rotate immediate [34:29], stage 2 [28:26], stage 1 [25:23], stage 0 [22:20], srcA [19:16], srcB [15:12], srcC [11:8], dstA [7:4], dstB [3:0]. Each stage field is {sideSel, op[1:0]}, with op 0=pass, 1=add, 2=rotate, 3=xor.
- R3: The add operator returns (in + side) mod 2^64.
- R4: The rotate operator rotates its input left by the 6-bit immediate, or by side[5:0] when the rotate-from-side bit is 1. An amount of 0 returns the input unchanged.
- R5: The xor operator returns in ^ side.
- R6: In chain mode, stage 0 takes rf[srcA], and stages 1 and 2 each take the previous stage's result. Stage 2's output is written to dstA, so reordering the stages changes the result.
- R7: In chain mode, a stage's side operand is rf[srcB] when its sideSel is 0 and rf[srcC] when it is 1.
- R8: In parallel mode, unit A is stage 0 applied to rf[srcA], and its result goes to dstA. Unit B is stage 1 applied to rf[srcC] with side rf[srcB] (sideSel 0) or rf[srcA] (sideSel 1), and its result goes to dstB. Stage 2 is ignored. wrA and wrB are both 1 in the result cycle.
- R9: When both parallel writes target the same entry, the entry ends up holding unit B's result.
- R10: A non-load configuration that uses the same non-pass operator in two active stages raises errOut in the result cycle. wrA and wrB stay 0 and the register file is left unchanged.
- R11: An issue is accepted on a clock edge where issueValid and issueReady are both 1. Its results and strobes are on the outputs in the next cycle, when issueReady is 0. The next accepted issue reads the updated register file.
- R12: An issue with issueLoad set writes loadData to dstA. resA equals loadData and wrA is 1 in the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issueValid | input | 1 | Issue request |
| issueReady | output | 1 | Element can accept an issue |
| issueLoad | input | 1 | Issue is a register load of loadData |
| loadData | input | 64 | Word written by a load issue |
| cfgWord | input | 37 | Operator, ordering and register selection |
| resA | output | 64 | Registered result for write port A |
| resB | output | 64 | Registered result for write port B |
| wrA | output | 1 | Port A write happens at the end of this cycle |
| wrB | output | 1 | Port B write happens at the end of this cycle |
| errOut | output | 1 | Illegal configuration was issued |

## Verification
The hardest case to reach is the collision of both parallel write ports on one entry. The outputs show only that both strobes fire, not which value the file kept. The stimulus therefore issues a parallel operation with dstA equal to dstB, then issues a pass-through read of that entry, which brings the stored word out on resA. The same read-back pattern confirms that a rejected configuration left its destination untouched.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W = 64;
  localparam int REG_N  = 16;
  localparam int ADDR_W = $clog2(REG_N);
  localparam int ROT_W  = $clog2(WORD_W);
  localparam int N_SLOT = 3;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_ADD  = 2'd1,
    OP_ROT  = 2'd2,
    OP_XOR  = 2'd3
  } arx_op_e;

  typedef struct packed {
    logic    sideSel;
    arx_op_e op;
  } slot_t;

  typedef struct packed {
    logic                    parMode;
    logic                    rotFromSide;
    logic [ROT_W-1:0]        rotImm;
    slot_t [N_SLOT-1:0]      slots;
    logic [ADDR_W-1:0]       srcA;
    logic [ADDR_W-1:0]       srcB;
    logic [ADDR_W-1:0]       srcC;
    logic [ADDR_W-1:0]       dstA;
    logic [ADDR_W-1:0]       dstB;
  } arx_cfg_t;

  localparam int CFG_W = $bits(arx_cfg_t);

  typedef struct packed {
    logic accept;
    logic load;
    logic parMode;
    logic weA;
    logic weB;
    logic err;
  } pe_strobe_t;
endpackage

// File: rtl/arx_unit.sv
module arx_unit
  import arx_pkg::*;
(
  input  arx_op_e           op,
  input  logic [WORD_W-1:0] inWord,
  input  logic [WORD_W-1:0] sideWord,
  input  logic [ROT_W-1:0]  rotImm,
  input  logic              rotFromSide,
  output logic [WORD_W-1:0] outWord
);
  logic [ROT_W-1:0]    rotAmt;
  logic [2*WORD_W-1:0] doubled;

  always_comb begin
    rotAmt  = rotFromSide ? sideWord[ROT_W-1:0] : rotImm;
    doubled = {inWord, inWord} << rotAmt;
    unique case (op)
      OP_ADD:  outWord = inWord + sideWord;
      OP_ROT:  outWord = doubled[2*WORD_W-1:WORD_W];
      OP_XOR:  outWord = inWord ^ sideWord;
      default: outWord = inWord;
    endcase
  end
endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issueValid,
  input  logic       issueLoad,
  input  arx_cfg_t   cfg,
  output logic       issueReady,
  output pe_strobe_t strb
);
  logic pending;
  logic illegal;
  logic accept;

  function automatic logic clash(arx_op_e a, arx_op_e b);
    return (a == b) && (a != OP_PASS);
  endfunction

  always_comb begin
    illegal = !issueLoad &&
              (clash(cfg.slots[0].op, cfg.slots[1].op) ||
               (!cfg.parMode && (clash(cfg.slots[0].op, cfg.slots[2].op) ||
                                 clash(cfg.slots[1].op, cfg.slots[2].op))));
    accept       = issueValid && !pending;
    issueReady   = !pending;
    strb.accept  = accept;
    strb.load    = issueLoad;
    strb.parMode = cfg.parMode && !issueLoad;
    strb.weA     = !illegal;
    strb.weB     = !illegal && cfg.parMode && !issueLoad;
    strb.err     = illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= accept;
  end

  a_r11_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !issueReady);
  a_r11_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !issueReady |=> issueReady);
endmodule

// File: rtl/arx_datapath.sv
module arx_datapath
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pe_strobe_t        strb,
  input  arx_cfg_t          cfg,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] resA,
  output logic [WORD_W-1:0] resB,
  output logic              wrA,
  output logic              wrB,
  output logic              errOut
);
  logic [WORD_W-1:0] rf [REG_N];
  logic [WORD_W-1:0] rdA, rdB, rdC;
  logic [WORD_W-1:0] unitIn   [N_SLOT];
  logic [WORD_W-1:0] unitSide [N_SLOT];
  logic [WORD_W-1:0] unitOut  [N_SLOT];
  logic [ADDR_W-1:0] dstAq, dstBq;

  always_comb begin
    rdA = rf[cfg.srcA];
    rdB = rf[cfg.srcB];
    rdC = rf[cfg.srcC];
    unitIn[0]   = rdA;
    unitSide[0] = cfg.slots[0].sideSel ? rdC : rdB;
    if (strb.parMode) begin
      unitIn[1]   = rdC;
      unitSide[1] = cfg.slots[1].sideSel ? rdA : rdB;
    end else begin
      unitIn[1]   = unitOut[0];
      unitSide[1] = cfg.slots[1].sideSel ? rdC : rdB;
    end
    unitIn[2]   = unitOut[1];
    unitSide[2] = cfg.slots[2].sideSel ? rdC : rdB;
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_stage
    arx_unit u_unit (
      .op         (cfg.slots[g].op),
      .inWord     (unitIn[g]),
      .sideWord   (unitSide[g]),
      .rotImm     (cfg.rotImm),
      .rotFromSide(cfg.rotFromSide),
      .outWord    (unitOut[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resA   <= '0;
      resB   <= '0;
      wrA    <= 1'b0;
      wrB    <= 1'b0;
      errOut <= 1'b0;
      dstAq  <= '0;
      dstBq  <= '0;
    end else if (strb.accept) begin
      resA   <= strb.load ? loadData : (strb.parMode ? unitOut[0] : unitOut[N_SLOT-1]);
      resB   <= strb.parMode ? unitOut[1] : '0;
      wrA    <= strb.weA;
      wrB    <= strb.weB;
      errOut <= strb.err;
      dstAq  <= cfg.dstA;
      dstBq  <= cfg.dstB;
    end else begin
      wrA    <= 1'b0;
      wrB    <= 1'b0;
      errOut <= 1'b0;
    end
  end

  // Port B is applied after port A so it wins a same-entry collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) rf[i] <= '0;
    end else begin
      if (wrA) rf[dstAq] <= resA;
      if (wrB) rf[dstBq] <= resB;
    end
  end

  a_r10_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    errOut |-> (!wrA && !wrB));
  a_r8_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrB |-> wrA);
  a_r9_port_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrB |=> rf[$past(dstBq)] == $past(resB));
  a_r12_load_result: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.accept && strb.load) |=> (resA == $past(loadData)) && wrA);
endmodule

// File: rtl/arx_pe.sv
module arx_pe
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic              issueLoad,
  input  logic [WORD_W-1:0] loadData,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic [WORD_W-1:0] resA,
  output logic [WORD_W-1:0] resB,
  output logic              wrA,
  output logic              wrB,
  output logic              errOut
);
  arx_cfg_t   cfg;
  pe_strobe_t strb;

  assign cfg = arx_cfg_t'(cfgWord);

  arx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .issueValid(issueValid),
    .issueLoad (issueLoad),
    .cfg       (cfg),
    .issueReady(issueReady),
    .strb      (strb)
  );

  arx_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .cfg     (cfg),
    .loadData(loadData),
    .resA    (resA),
    .resB    (resB),
    .wrA     (wrA),
    .wrB     (wrB),
    .errOut  (errOut)
  );
endmodule

// File: tb/arx_pe_tb.sv
module arx_pe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueReady;
  logic        issueLoad = 1'b0;
  logic [63:0] loadData = '0;
  logic [36:0] cfgWord = '0;
  logic [63:0] resA, resB;
  logic        wrA, wrB, errOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  arx_pe dut_i (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueReady(issueReady),
    .issueLoad(issueLoad), .loadData(loadData), .cfgWord(cfgWord),
    .resA(resA), .resB(resB), .wrA(wrA), .wrB(wrB), .errOut(errOut)
  );

  typedef struct {
    logic [63:0] eA;
    logic [63:0] eB;
    logic        eWrA;
    logic        eWrB;
    logic        eErr;
    bit          cmpA;
    bit          cmpB;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [63:0] mrf [16];

  localparam logic [1:0] P = 2'd0, AD = 2'd1, RO = 2'd2, XO = 2'd3;

  function automatic logic [36:0] mk(input logic par, input logic rs, input logic [5:0] imm,
      input logic [1:0] o0, input logic s0, input logic [1:0] o1, input logic s1,
      input logic [1:0] o2, input logic s2,
      input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
      input logic [3:0] da, input logic [3:0] db);
    return {par, rs, imm, s2, o2, s1, o1, s0, o0, a, b, c, da, db};
  endfunction

  function automatic logic [63:0] mrot(input logic [63:0] x, input int amt);
    if (amt == 0) return x;
    return (x << amt) | (x >> (64 - amt));
  endfunction

  function automatic logic [63:0] mop(input logic [1:0] op, input logic [63:0] x,
      input logic [63:0] s, input logic [5:0] imm, input logic rs);
    case (op)
      AD: return x + s;
      RO: return mrot(x, rs ? int'(s[5:0]) : int'(imm));
      XO: return x ^ s;
      default: return x;
    endcase
  endfunction

  function automatic bit dupOp(input logic [1:0] a, input logic [1:0] b);
    return (a == b) && (a != P);
  endfunction

  task automatic issue(input logic [36:0] cw, input logic ld, input logic [63:0] d, input string tag);
    exp_t e;
    logic par, rs, s0, s1, s2;
    logic [5:0] imm;
    logic [1:0] o0, o1, o2;
    logic [3:0] a, b, c, da, db;
    logic [63:0] v;
    bit bad;
    {par, rs, imm, s2, o2, s1, o1, s0, o0, a, b, c, da, db} = cw;
    while (!issueReady) @(negedge clk);
    e.tag = tag; e.eA = '0; e.eB = '0; e.cmpA = 1; e.cmpB = 0;
    e.eWrA = 1; e.eWrB = 0; e.eErr = 0;
    if (ld) begin
      e.eA = d;
      mrf[da] = d;
    end else begin
      bad = dupOp(o0, o1) || (!par && (dupOp(o0, o2) || dupOp(o1, o2)));
      if (bad) begin
        e.eWrA = 0; e.eErr = 1; e.cmpA = 0;
      end else if (par) begin
        e.eA = mop(o0, mrf[a], s0 ? mrf[c] : mrf[b], imm, rs);
        e.eB = mop(o1, mrf[c], s1 ? mrf[a] : mrf[b], imm, rs);
        e.eWrB = 1; e.cmpB = 1;
        mrf[da] = e.eA;
        mrf[db] = e.eB;
      end else begin
        v = mop(o0, mrf[a], s0 ? mrf[c] : mrf[b], imm, rs);
        v = mop(o1, v, s1 ? mrf[c] : mrf[b], imm, rs);
        v = mop(o2, v, s2 ? mrf[c] : mrf[b], imm, rs);
        e.eA = v;
        mrf[da] = v;
      end
    end
    expQ.push_back(e);
    cfgWord = cw; issueLoad = ld; loadData = d; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0; issueLoad = 1'b0;
  endtask

  task automatic readBack(input logic [3:0] r, input string tag);
    issue(mk(0, 0, 6'd0, P, 0, P, 0, P, 0, r, 4'd0, 4'd0, r, 4'd0), 1'b0, 64'd0, tag);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: every accepted issue produces exactly one result cycle with issueReady low.
  always @(negedge clk) begin
    if (rst_n && !issueReady) begin
      if (expQ.size() == 0) begin
        chk(0, "R11", "unexpected result cycle", 64'd0, 64'd1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(wrA === e.eWrA, e.tag, "wrA", {63'd0, wrA}, {63'd0, e.eWrA});
        chk(wrB === e.eWrB, e.tag, "wrB", {63'd0, wrB}, {63'd0, e.eWrB});
        chk(errOut === e.eErr, e.tag, "errOut", {63'd0, errOut}, {63'd0, e.eErr});
        if (e.cmpA) chk(resA === e.eA, e.tag, "resA", resA, e.eA);
        if (e.cmpB) chk(resB === e.eB, e.tag, "resB", resB, e.eB);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mrf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(issueReady === 1'b1, "R1", "issueReady", {63'd0, issueReady}, 64'd1);
    chk(!wrA && !wrB && !errOut, "R1", "strobes", {61'd0, wrA, wrB, errOut}, 64'd0);
    chk(resA === 64'd0 && resB === 64'd0, "R1", "results", resA, 64'd0);
    readBack(4'd9, "R1 rf zero");

    // R12 loads
    issue(mk(0,0,0,P,0,P,0,P,0,0,0,0,4'd1,0), 1'b1, 64'h0123456789ABCDEF, "R12");
    issue(mk(0,0,0,P,0,P,0,P,0,0,0,0,4'd2,0), 1'b1, 64'hFFFFFFFFFFFFFFFF, "R12");
    issue(mk(0,0,0,P,0,P,0,P,0,0,0,0,4'd3,0), 1'b1, 64'h8000000000000001, "R12");
    issue(mk(0,0,0,P,0,P,0,P,0,0,0,0,4'd4,0), 1'b1, 64'h0000000000000003, "R12");
    issue(mk(0,0,0,P,0,P,0,P,0,0,0,0,4'd5,0), 1'b1, 64'hA5A5F0F00FF05A5A, "R12");
    readBack(4'd1, "R12 readback");

    // R2, R3: single add wrapping modulo 2^64
    issue(mk(0,0,0,AD,0,P,0,P,0,4'd1,4'd2,0,4'd6,0), 1'b0, 0, "R2 R3 add wrap");
    // R11: next issue reads r6 just written
    readBack(4'd6, "R11 back-to-back");
    // R4 rotate: amount 0, immediate 13, side amount 3
    issue(mk(0,0,6'd0,RO,0,P,0,P,0,4'd3,0,0,4'd7,0), 1'b0, 0, "R4 rot zero");
    issue(mk(0,0,6'd13,RO,0,P,0,P,0,4'd3,0,0,4'd7,0), 1'b0, 0, "R4 rot imm");
    issue(mk(0,1,6'd13,RO,0,P,0,P,0,4'd1,4'd4,0,4'd8,0), 1'b0, 0, "R4 rot side");
    // R5 xor
    issue(mk(0,0,0,XO,0,P,0,P,0,4'd1,4'd5,0,4'd9,0), 1'b0, 0, "R5 xor");
    // R6 ordering: add-rot-xor vs xor-rot-add
    issue(mk(0,0,6'd7,AD,0,RO,0,XO,1,4'd1,4'd5,4'd3,4'd10,0), 1'b0, 0, "R6 add rot xor");
    issue(mk(0,0,6'd7,XO,1,RO,0,AD,0,4'd1,4'd5,4'd3,4'd11,0), 1'b0, 0, "R6 xor rot add");
    issue(mk(0,0,6'd5,P,0,RO,0,P,0,4'd5,0,0,4'd12,0), 1'b0, 0, "R6 bypass slots");
    // R7 side select
    issue(mk(0,0,0,AD,1,P,0,P,0,4'd1,4'd2,4'd5,4'd13,0), 1'b0, 0, "R7 side rdC");
    // R8 parallel, stage 2 duplicate is ignored
    issue(mk(1,0,6'd9,AD,0,XO,1,AD,0,4'd1,4'd5,4'd3,4'd14,4'd15), 1'b0, 0, "R8 parallel");
    readBack(4'd14, "R8 readback A");
    readBack(4'd15, "R8 readback B");
    // R9 same destination: B wins
    issue(mk(1,0,6'd4,RO,0,AD,0,P,0,4'd5,4'd2,4'd1,4'd6,4'd6), 1'b0, 0, "R9 collide");
    readBack(4'd6, "R9 readback");
    // R10 illegal chain and illegal parallel leave state unchanged
    issue(mk(0,0,0,AD,0,XO,0,AD,0,4'd1,4'd2,0,4'd5,0), 1'b0, 0, "R10 chain dup");
    issue(mk(1,0,0,XO,0,XO,0,P,0,4'd1,4'd2,4'd3,4'd4,4'd4), 1'b0, 0, "R10 parallel dup");
    readBack(4'd5, "R10 readback");
    readBack(4'd4, "R10 readback");

    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule